// File: doc/BRIEF.md
# Multi-Wave Issue Scheduler

This block chooses, on each clock cycle, which waves of a SIMD core may issue their next instruction to a small pool of shared execution units. The default pool holds two SIMD ALUs and one texture sampler, and four waves compete for it. Each wave supplies a ready flag and the unit class of its pending instruction. The scheduler returns the per-wave grants and the assignment of each unit in the same cycle. The instruction source acts on those grants.

An ALU that is narrower than the wave stays occupied for several cycles per instruction. The scheduler counts those cycles down, and it counts the sampler's occupancy in the same way. A wave that issues a sampler access or a long ALU operation is parked. Parked waves are skipped until a per-wave completion pulse wakes them, so the other waves keep the ALUs busy. A round-robin pointer keeps any ready wave from starving. Two counters per ALU report how many cycles the ALU was busy and how many cycles it sat idle while work was waiting.

Top module: `issue_sched`

## Requirements
- R1: A synchronous active-low reset clears every parked flag, frees every unit, zeroes every counter and sets the round-robin pointer to wave 0. While reset is held with no wave ready, no grant is made.
- R2: A cycle grants at most ISSUE_WIDTH waves. A wave is granted only if its ready bit is set and it is not parked. Grants are combinational in the cycle of the request.
- R3: Each wave's class field is 2 bits wide, and wave w uses bits [2w+1:2w]. The codes are: 00 is a short ALU operation, 01 is a sampler access, and 10 or 11 is a long ALU operation. An ALU-class grant takes the lowest-numbered free ALU. It raises that ALU's `alu_issue` bit and places the wave index in that ALU's `alu_wave` slot. ALU a uses bits [a*WIX +: WIX].
- R4: A granted ALU is occupied for CHIME = WAVE_WIDTH/ALU_WIDTH cycles, counting the grant cycle. It receives no grant until those cycles have passed.
- R5: The sampler receives at most one grant per cycle, and only when it is free. A grant holds it for SMP_BUSY cycles. The grant is reported on `smp_issue` and `smp_wave`.
- R6: A wave granted with class 01, 10 or 11 is parked from the next cycle. It receives no grant while parked.
- R7: A pulse on `stall_done[w]` unparks wave w. The wave can be granted in the cycle after the pulse.
- R8: The scan for candidates starts at the wave after the last wave granted, in circular order. If a cycle makes no grant, the starting point does not move.
- R9: An eligible wave that finds no free unit of its class, or that arrives after the issue width is used up, stays pending and is not granted.
- R10: Each ALU's busy counter increments in every cycle in which that ALU is granted or still occupied.
- R11: Each ALU's starve counter increments in every cycle in which that ALU is neither granted nor occupied while at least one eligible wave goes ungranted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wave_ready | input | NUM_WAVES | Wave has an instruction ready |
| wave_cls | input | 2*NUM_WAVES | Unit class of each wave's next instruction |
| stall_done | input | NUM_WAVES | Completion pulse that unparks a wave |
| grant | output | NUM_WAVES | Wave may issue this cycle |
| alu_issue | output | NUM_ALUS | ALU receives an instruction this cycle |
| alu_wave | output | NUM_ALUS*WIX | Wave index assigned to each ALU |
| smp_issue | output | 1 | Sampler receives an instruction this cycle |
| smp_wave | output | WIX | Wave index assigned to the sampler |
| alu_busy_cycles | output | NUM_ALUS*CNT_W | Per-ALU busy cycle count |
| alu_starve_cycles | output | NUM_ALUS*CNT_W | Per-ALU idle-while-pending cycle count |

## Verification
The bench builds the block with its defaults: four waves, issue width 2, two ALUs, a 32-lane wave on 16-lane ALUs (chime 2) and a sampler that is busy for two cycles. With chime 2, every other cycle finds both ALUs occupied, which exposes the pending and hold-off behaviour. The two-cycle sampler lets two sampler requests in a row show both the one-grant-per-cycle limit and the idle ALUs counted as starved. Width 2 against four ready waves makes the round-robin rotation visible within three cycles.

// File: rtl/sched_pkg.sv
// Shared definitions for the issue scheduler.
// Assumes a 2-bit class code per wave.
package sched_pkg;
    typedef enum logic [1:0] {
        OP_ALU   = 2'b00,
        OP_SMP   = 2'b01,
        OP_LONG  = 2'b10,
        OP_LONGX = 2'b11
    } op_cls_e;

    // True when the class needs an ALU.
    function automatic logic uses_alu(input op_cls_e c);
        return c != OP_SMP;
    endfunction

    // True when issuing the class parks the wave.
    function automatic logic parks_wave(input op_cls_e c);
        return c != OP_ALU;
    endfunction
endpackage

// File: rtl/unit_timer.sv
// Occupancy timer for one execution unit.
// A grant holds the unit for BUSY cycles, counting the grant cycle.
// Assumes that go is raised only while free is high.
module unit_timer #(
    parameter int BUSY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic free
);
    localparam int CW = (BUSY > 1) ? $clog2(BUSY) : 1;

    logic [CW-1:0] left;

    // Load the remaining busy cycles on a grant, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           left <= '0;
        else if (go)          left <= CW'(BUSY - 1);
        else if (left != '0)  left <= left - 1'b1;
    end

    assign free = (left == '0);

    // R4 R5
    grant_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> free);

    generate
        if (BUSY > 1) begin : g_hold
            // R4 R5
            hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
                go |=> !free);
        end
    endgenerate
endmodule

// File: rtl/wave_park.sv
// Parked flags for the waves.
// A flag is set when a long-latency or sampler grant occurs and cleared by a completion pulse.
// Assumes set and clr never target the same wave in one cycle. If they do, set wins.
module wave_park #(
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] set,
    input  logic [NW-1:0] clr,
    output logic [NW-1:0] parked
);
    // Hold, set or clear each wave's parked flag.
    always_ff @(posedge clk) begin
        if (!rst_n) parked <= '0;
        else        parked <= (parked & ~clr) | set;
    end

    generate
        for (genvar w = 0; w < NW; w++) begin : g_chk
            // R6
            park_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set[w] |=> parked[w]);
            // R7
            park_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[w] && !set[w]) |=> !parked[w]);
        end
    endgenerate
endmodule

// File: rtl/issue_pick.sv
// Combinational round-robin selection.
// Scans the waves from ptr in circular order. A wave is granted while the issue
// width lasts and a free unit of its class remains; ALUs are taken lowest index first.
// Assumes elig already excludes parked waves.
module issue_pick
    import sched_pkg::*;
#(
    parameter int NW  = 4,
    parameter int NA  = 2,
    parameter int IW  = 2,
    parameter int WIX = 2
) (
    input  logic [WIX-1:0]    ptr,
    input  logic [NW-1:0]     elig,
    input  logic [2*NW-1:0]   cls,
    input  logic [NA-1:0]     alu_free,
    input  logic              smp_free,
    output logic [NW-1:0]     grant,
    output logic [NA-1:0]     alu_go,
    output logic [NA*WIX-1:0] alu_who,
    output logic              smp_go,
    output logic [WIX-1:0]    smp_who,
    output logic              any,
    output logic [WIX-1:0]    last
);
    // Walk the waves once and hand out units greedily.
    always_comb begin : pick
        logic [NA-1:0] a_av;
        logic          s_av;
        logic          took;
        int            n;
        int            w;
        a_av    = alu_free;
        s_av    = smp_free;
        took    = 1'b0;
        n       = 0;
        w       = 0;
        grant   = '0;
        alu_go  = '0;
        alu_who = '0;
        smp_go  = 1'b0;
        smp_who = '0;
        any     = 1'b0;
        last    = '0;
        for (int k = 0; k < NW; k++) begin
            w = (int'(ptr) + k) % NW;
            if (elig[w] && n < IW) begin
                if (!uses_alu(op_cls_e'(cls[2*w +: 2]))) begin
                    if (s_av) begin
                        s_av     = 1'b0;
                        smp_go   = 1'b1;
                        smp_who  = WIX'(w);
                        grant[w] = 1'b1;
                        n++;
                    end
                end else begin
                    took = 1'b0;
                    for (int a = 0; a < NA; a++) begin
                        if (!took && a_av[a]) begin
                            took                  = 1'b1;
                            a_av[a]               = 1'b0;
                            alu_go[a]             = 1'b1;
                            alu_who[a*WIX +: WIX] = WIX'(w);
                        end
                    end
                    if (took) begin
                        grant[w] = 1'b1;
                        n++;
                    end
                end
                if (grant[w]) begin
                    any  = 1'b1;
                    last = WIX'(w);
                end
            end
        end
    end
endmodule

// File: rtl/util_count.sv
// Busy and starve cycle counters for one ALU. The counters wrap on overflow.
module util_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          starve,
    output logic [CW-1:0] busy_cnt,
    output logic [CW-1:0] starve_cnt
);
    // Count occupied cycles and cycles spent idle while a wave waits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt   <= '0;
            starve_cnt <= '0;
        end else begin
            if (busy)   busy_cnt   <= busy_cnt + 1'b1;
            if (starve) starve_cnt <= starve_cnt + 1'b1;
        end
    end

    // R10 R11
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && starve));
endmodule

// File: rtl/issue_sched.sv
// Multi-wave issue scheduler: the top level.
// Grants up to ISSUE_WIDTH ready, unparked waves per cycle onto NUM_ALUS ALUs and one sampler.
// Assumes the instruction source holds each request until it is granted.
module issue_sched
    import sched_pkg::*;
#(
    parameter int NUM_WAVES   = 4,
    parameter int NUM_ALUS    = 2,
    parameter int ISSUE_WIDTH = 2,
    parameter int WAVE_WIDTH  = 32,
    parameter int ALU_WIDTH   = 16,
    parameter int SMP_BUSY    = 2,
    parameter int CNT_W       = 16,
    localparam int WIX        = (NUM_WAVES > 1) ? $clog2(NUM_WAVES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_WAVES-1:0]      wave_ready,
    input  logic [2*NUM_WAVES-1:0]    wave_cls,
    input  logic [NUM_WAVES-1:0]      stall_done,
    output logic [NUM_WAVES-1:0]      grant,
    output logic [NUM_ALUS-1:0]       alu_issue,
    output logic [NUM_ALUS*WIX-1:0]   alu_wave,
    output logic                      smp_issue,
    output logic [WIX-1:0]            smp_wave,
    output logic [NUM_ALUS*CNT_W-1:0] alu_busy_cycles,
    output logic [NUM_ALUS*CNT_W-1:0] alu_starve_cycles
);
    localparam int CHIME = (WAVE_WIDTH / ALU_WIDTH > 0) ? WAVE_WIDTH / ALU_WIDTH : 1;

    logic [WIX-1:0]       ptr;
    logic [NUM_WAVES-1:0] parked, elig, park_set, smp_req, park_req;
    logic [NUM_ALUS-1:0]  alu_free;
    logic                 smp_free, any;
    logic [WIX-1:0]       last;
    logic                 pending;

    assign elig = wave_ready & ~parked;

    // Decode the class of every wave: does it want the sampler, and does it park.
    always_comb begin
        for (int w = 0; w < NUM_WAVES; w++) begin
            smp_req[w]  = !uses_alu(op_cls_e'(wave_cls[2*w +: 2]));
            park_req[w] = parks_wave(op_cls_e'(wave_cls[2*w +: 2]));
        end
    end

    assign park_set = grant & park_req;

    issue_pick #(.NW(NUM_WAVES), .NA(NUM_ALUS), .IW(ISSUE_WIDTH), .WIX(WIX)) u_pick (
        .ptr(ptr), .elig(elig), .cls(wave_cls), .alu_free(alu_free), .smp_free(smp_free),
        .grant(grant), .alu_go(alu_issue), .alu_who(alu_wave), .smp_go(smp_issue),
        .smp_who(smp_wave), .any(any), .last(last)
    );

    wave_park #(.NW(NUM_WAVES)) u_park (
        .clk(clk), .rst_n(rst_n), .set(park_set), .clr(stall_done), .parked(parked)
    );

    unit_timer #(.BUSY(SMP_BUSY)) u_smp_t (
        .clk(clk), .rst_n(rst_n), .go(smp_issue), .free(smp_free)
    );

    assign pending = |(elig & ~grant);

    generate
        for (genvar a = 0; a < NUM_ALUS; a++) begin : g_alu
            logic occ;
            unit_timer #(.BUSY(CHIME)) u_t (
                .clk(clk), .rst_n(rst_n), .go(alu_issue[a]), .free(alu_free[a])
            );
            assign occ = alu_issue[a] | ~alu_free[a];
            util_count #(.CW(CNT_W)) u_cnt (
                .clk(clk), .rst_n(rst_n), .busy(occ), .starve(~occ & pending),
                .busy_cnt(alu_busy_cycles[a*CNT_W +: CNT_W]),
                .starve_cnt(alu_starve_cycles[a*CNT_W +: CNT_W])
            );
        end
    endgenerate

    // Advance the round-robin pointer past the last wave granted.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= '0;
        else if (any) ptr <= (int'(last) == NUM_WAVES - 1) ? '0 : last + 1'b1;
    end

    // R2
    issue_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) <= ISSUE_WIDTH);
    // R2
    ready_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~wave_ready) == '0);
    // R6
    parked_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & parked) == '0);
    // R5
    smp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant & smp_req) <= 1);
    // R3
    alu_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(alu_issue) == $countones(grant & ~smp_req));
endmodule

// File: tb/sim_issue_sched.sv
module sim_issue_sched;
    localparam int NW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ready = '0;
    logic [7:0]  cls = '0;
    logic [3:0]  done = '0;
    logic [3:0]  grant;
    logic [1:0]  alu_issue;
    logic [3:0]  alu_wave;
    logic        smp_issue;
    logic [1:0]  smp_wave;
    logic [31:0] busy_c, starve_c;
    int          errors = 0;
    int          checks = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    issue_sched u0 (
        .clk(clk), .rst_n(rst_n), .wave_ready(ready), .wave_cls(cls), .stall_done(done),
        .grant(grant), .alu_issue(alu_issue), .alu_wave(alu_wave), .smp_issue(smp_issue),
        .smp_wave(smp_wave), .alu_busy_cycles(busy_c), .alu_starve_cycles(starve_c)
    );

    // Each row is {ready, class, stall_done, expected grant}. Class bits per wave: 00 ALU, 01 sampler, 1x long.
    localparam logic [19:0] VEC [10] = '{
        {4'b1111, 8'b00_00_00_00, 4'b0000, 4'b0011}, // R2 R8: width 2 from wave 0
        {4'b1111, 8'b00_00_00_00, 4'b0000, 4'b0000}, // R4 R9: both ALUs inside chime
        {4'b1111, 8'b00_00_00_00, 4'b0000, 4'b1100}, // R8: rotate to waves 2,3
        {4'b1111, 8'b00_00_00_01, 4'b0000, 4'b0001}, // R5 R9: sampler only
        {4'b1111, 8'b00_00_01_01, 4'b0000, 4'b1100}, // R5 R6: sampler busy, wave 0 parked
        {4'b1111, 8'b00_10_01_01, 4'b0000, 4'b0010}, // R5: sampler free again
        {4'b1111, 8'b10_10_01_01, 4'b0000, 4'b1100}, // R3: long ops take ALUs
        {4'b1111, 8'b10_10_01_01, 4'b0001, 4'b0000}, // R6: all parked, wake wave 0
        {4'b1111, 8'b10_10_01_00, 4'b0000, 4'b0001}, // R7: woken wave granted
        {4'b1111, 8'b10_10_01_00, 4'b0000, 4'b0001}  // R3 R6: lowest free ALU is 1
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ready = '0; cls = '0; done = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: got hang expected completion");
            summary();
        end
    end

    initial begin
        do_reset();
        #1;
        check("R1 grant", grant, 0);
        check("R1 busy", busy_c, 0);
        check("R1 starve", starve_c, 0);

        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            {ready, cls, done} = VEC[i][19:4];
            #1;
            check($sformatf("R2 R8 vector %0d", i), grant, VEC[i][3:0]);
            if (i == 9) begin
                check("R3 alu_issue", alu_issue, 2'b10);
                check("R3 alu_wave", alu_wave[3:2], 0);
            end
            if (i == 8) check("R3 ALU0 pick", alu_issue, 2'b01);
        end
        @(negedge clk);
        ready = '0; done = '0;
        #1;
        check("R10 busy ALU0", busy_c[15:0], 10);
        check("R10 busy ALU1", busy_c[31:16], 9);
        check("R11 starve ALU0", starve_c[15:0], 0);
        check("R11 starve ALU1", starve_c[31:16], 0);

        // Two sampler requests in a row after a fresh reset.
        do_reset();
        ready = 4'b0011; cls = 8'b00_00_01_01;
        #1;
        check("R5 single sampler", grant, 4'b0001);
        check("R5 smp_wave", {smp_issue, smp_wave}, 3'b100);
        @(negedge clk); #1;
        check("R11 starve after 1", starve_c, {16'd1, 16'd1});
        check("R5 sampler busy", grant, 4'b0000);
        @(negedge clk); #1;
        check("R11 starve after 2", starve_c, {16'd2, 16'd2});
        check("R8 R5 next sampler", grant, 4'b0010);
        @(negedge clk);
        ready = '0;
        #1;
        check("R11 no pending", starve_c, {16'd2, 16'd2});
        check("R10 idle ALUs", busy_c, 0);

        finished = 1'b1;
        summary();
    end
endmodule